// File: doc/BRIEF.md
# Response packet error checker

This block sits on the receive side of a serial memory-cube link, after CRC evaluation, and judges each arriving response packet. It checks that the packet's length field and its duplicate agree and lie in the legal range, that the CRC result is good, and that the 3-bit sequence number is the one expected next. A packet that fails any of these checks is a link error. It is discarded, a one-cycle abort request asks the link layer to enter its retry (error-abort) flow, a sticky interrupt-status bit records the cause, and a saturating local error counter advances.

A packet that passes the link checks is routed on its error-status field. A zero status, or a nonzero status in a read, write or mode response, is forwarded to the data-path output one cycle later. A nonzero status raises the response-error flag beside the packet. An error-response packet with a nonzero status is not forwarded. Its status and cube ID go into an eight-entry queue whose head software reads through a register, so closely spaced error responses are kept. Reading the head pops it.

Top module: `rsp_err_checker`

## Requirements
- R1: A valid packet whose length and duplicate length differ, or whose length lies outside 1..MAX_LEN (default 9), is discarded and sets interrupt-status bit 0 (register address 1).
- R2: A valid packet with crc_ok low is discarded and sets interrupt-status bit 1.
- R3: The expected sequence number resets to 0, wraps from 7 to 0, and advances only on packets that pass every link check. A valid packet with another sequence number is discarded and sets interrupt-status bit 2.
- R4: Every link-errored packet raises abort_req for exactly the following cycle and increments the local error counter (register address 2) once. The counter holds at its maximum (255).
- R5: A clean packet with error status zero appears on the output one cycle after input, with its data and kind unchanged and rsp_err low.
- R6: A clean read (kind 0), write (kind 1) or mode (kind 2) response with nonzero error status is forwarded with rsp_err high.
- R7: A clean error response (kind 3) with nonzero error status is not forwarded. Its cube ID and error status are appended to the error queue.
- R8: Register address 0 shows the queue head as errstat in bits 6:0, cube in bits 9:7 and a head-valid flag in bit 10. A read strobe at address 0 pops the head, and entries leave in arrival order.
- R9: With 8 entries queued, a further error response is dropped and sets the sticky overflow bit 15 of address 0. Writing 1 to bit 15 at address 0 clears it.
- R10: Interrupt-status bits stay set until a write to address 1 with a 1 in their position. Bits written 0 are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet present this cycle |
| in_kind | input | 2 | 0 read, 1 write, 2 mode, 3 error response |
| in_len | input | 4 | Length field |
| in_dup_len | input | 4 | Duplicate length field |
| in_crc_ok | input | 1 | CRC check result from upstream |
| in_seq | input | 3 | Sequence number |
| in_errstat | input | 7 | Error-status field |
| in_cube | input | 3 | Cube ID |
| in_data | input | 32 | Packet payload |
| out_valid | output | 1 | Forwarded packet present |
| out_kind | output | 2 | Kind of forwarded packet |
| out_data | output | 32 | Payload of forwarded packet |
| out_rsp_err | output | 1 | Forwarded packet carried a nonzero error status |
| abort_req | output | 1 | Request to enter error-abort mode |
| rd_en | input | 1 | Register read strobe (pops queue at address 0) |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data |
| wr_en | input | 1 | Register write strobe (write-1-to-clear) |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |

## Verification
The routing is tried with clean zero-status packets of every kind across a sequence wrap, which separates plain forwarding from flagged forwarding, and with nonzero status in each response kind, which separates flagged forwarding from diversion. Each link check is broken alone: unequal lengths, a zero length, an oversized length, a bad CRC and a skipped sequence number. Each case must leave no output, raise abort, set only its own status bit and leave the expected sequence unchanged. A burst of nine error responses shows queue order and the dropped ninth entry. A long run of CRC failures drives the counter into saturation.

// File: rtl/rsp_err_checker.sv
module rsp_err_checker #(
  parameter int DW      = 32,
  parameter int LENW    = 4,
  parameter int MAX_LEN = 9,
  parameter int SEQW    = 3,
  parameter int ESW     = 7,
  parameter int CUBEW   = 3,
  parameter int DEPTH   = 8,
  parameter int CNTW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_kind,
  input  logic [LENW-1:0]  in_len,
  input  logic [LENW-1:0]  in_dup_len,
  input  logic             in_crc_ok,
  input  logic [SEQW-1:0]  in_seq,
  input  logic [ESW-1:0]   in_errstat,
  input  logic [CUBEW-1:0] in_cube,
  input  logic [DW-1:0]    in_data,
  output logic             out_valid,
  output logic [1:0]       out_kind,
  output logic [DW-1:0]    out_data,
  output logic             out_rsp_err,
  output logic             abort_req,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [15:0]      rd_data,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [15:0]      wr_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = ESW + CUBEW;
  localparam logic [CNTW-1:0] CMAX = '1;
  localparam logic [1:0] K_ERR = 2'd3;

  logic [SEQW-1:0] exp_seq;
  logic [2:0]      irq;
  logic [CNTW-1:0] err_cnt;
  logic            ovf;
  logic [EW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [AW:0]     fcnt;

  wire len_bad  = (in_len != in_dup_len) || (in_len == '0) || (int'(in_len) > MAX_LEN);
  wire crc_bad  = !in_crc_ok;
  wire seq_bad  = in_seq != exp_seq;
  wire link_err = in_valid && (len_bad || crc_bad || seq_bad);
  wire clean    = in_valid && !link_err;
  wire es_nz    = in_errstat != '0;
  wire divert   = clean && in_kind == K_ERR && es_nz;
  wire full     = fcnt == (AW+1)'(DEPTH);
  wire empty    = fcnt == '0;
  wire pop      = rd_en && rd_addr == 2'd0 && !empty;
  wire push     = divert && (!full || pop);
  wire clr_ovf  = wr_en && wr_addr == 2'd0 && wr_data[15];
  wire [2:0] irq_clr = (wr_en && wr_addr == 2'd1) ? wr_data[2:0] : 3'b000;
  wire [2:0] irq_set = link_err ? {seq_bad, crc_bad, len_bad} : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_kind    <= '0;
      out_data    <= '0;
      out_rsp_err <= 1'b0;
      abort_req   <= 1'b0;
    end else begin
      out_valid   <= clean && !divert;
      out_kind    <= in_kind;
      out_data    <= in_data;
      out_rsp_err <= clean && es_nz;
      abort_req   <= link_err;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_seq <= '0;
      irq     <= '0;
      err_cnt <= '0;
      ovf     <= 1'b0;
    end else begin
      if (clean) exp_seq <= exp_seq + 1'b1;
      irq <= (irq & ~irq_clr) | irq_set;
      if (link_err && err_cnt != CMAX) err_cnt <= err_cnt + 1'b1;
      if (divert && full && !pop) ovf <= 1'b1;
      else if (clr_ovf) ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {in_cube, in_errstat};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fcnt <= '0;
    end else begin
      if (push) wp <= (int'(wp) == DEPTH-1) ? '0 : wp + 1'b1;
      if (pop)  rp <= (int'(rp) == DEPTH-1) ? '0 : rp + 1'b1;
      fcnt <= fcnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      2'd0: begin
        if (!empty) rd_data[EW-1:0] = mem[rp];
        rd_data[EW] = !empty;
        rd_data[15] = ovf;
      end
      2'd1: rd_data[2:0] = irq;
      2'd2: rd_data[CNTW-1:0] = err_cnt;
      default: rd_data = '0;
    endcase
  end

  assert_crc_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_crc_ok |=> abort_req && !out_valid && irq[1]);

  assert_len_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_len != in_dup_len |=> abort_req && !out_valid && irq[0]);

  assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt == CMAX |=> err_cnt == CMAX);

  assert_seq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(exp_seq));

  assert_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clean && in_kind != K_ERR && in_errstat != '0 |=> out_valid && out_rsp_err);

  assert_divert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clean && in_kind == K_ERR && in_errstat != '0 |=> !out_valid);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    full && divert && !pop |=> ovf && full);

  assert_fifo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fcnt) <= DEPTH);
endmodule

// File: tb/tb_rsp_err_checker.sv
module tb_rsp_err_checker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_crc_ok = 1'b1;
  logic [1:0] in_kind = '0;
  logic [3:0] in_len = '0, in_dup_len = '0;
  logic [2:0] in_seq = '0, in_cube = '0;
  logic [6:0] in_errstat = '0;
  logic [31:0] in_data = '0;
  logic out_valid, out_rsp_err, abort_req;
  logic [1:0] out_kind;
  logic [31:0] out_data;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0] rd_addr = '0, wr_addr = '0;
  logic [15:0] rd_data, wr_data = '0;

  rsp_err_checker dut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  logic [34:0] sb [$];
  logic [9:0]  mq [$];
  logic [2:0]  m_seq = '0, m_irq = '0;
  int          m_cnt = 0;
  logic        m_ovf = 1'b0;

  task automatic chk(string tag, logic [34:0] act, logic [34:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R5/R7 unexpected forward actual=%0h expected=none", out_data);
      end else begin
        logic [34:0] e;
        e = sb.pop_front();
        if ({out_kind, out_rsp_err, out_data} !== e) begin
          bad++;
          $display("FAIL R5/R6 forward actual=%0h expected=%0h",
                   {out_kind, out_rsp_err, out_data}, e);
        end
      end
    end
  end

  task automatic send(logic [1:0] k, logic [3:0] l, logic [3:0] dl, logic c,
                      logic [2:0] s, logic [6:0] es, logic [2:0] cb, logic [31:0] d);
    logic le;
    le = (l != dl) || l == 0 || l > 9 || !c || s != m_seq;
    in_valid = 1'b1; in_kind = k; in_len = l; in_dup_len = dl; in_crc_ok = c;
    in_seq = s; in_errstat = es; in_cube = cb; in_data = d;
    if (le) begin
      m_irq |= {s != m_seq, !c, (l != dl) || l == 0 || l > 9};
      if (m_cnt < 255) m_cnt++;
    end else begin
      m_seq++;
      if (k == 3 && es != 0) begin
        if (mq.size() < 8) mq.push_back({cb, es});
        else m_ovf = 1'b1;
      end else sb.push_back({k, es != 0, d});
    end
    @(negedge clk);
    chk("R4 abort_req", 35'(abort_req), 35'(le));
    #1 in_valid = 1'b0;
  endtask

  task automatic good(logic [1:0] k, logic [6:0] es, logic [2:0] cb, logic [31:0] d);
    send(k, 4'd1, 4'd1, 1'b1, m_seq, es, cb, d);
  endtask

  task automatic peek(logic [1:0] a, output logic [15:0] v);
    rd_addr = a; #1 v = rd_data;
  endtask

  task automatic pop();
    rd_addr = 2'd0; rd_en = 1'b1;
    @(negedge clk); #1 rd_en = 1'b0;
    void'(mq.pop_front());
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic check_regs(string tag);
    logic [15:0] v;
    peek(2'd0, v);
    chk({tag, " R8 head"}, 35'(v),
        35'({m_ovf, 4'b0, mq.size() != 0, (mq.size() != 0) ? mq[0] : 10'd0}));
    peek(2'd1, v);
    chk({tag, " R10 irq"}, 35'(v), 35'(m_irq));
    peek(2'd2, v);
    chk({tag, " R4 count"}, 35'(v), 35'(m_cnt));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    chk("reset out_valid", 35'(out_valid), 35'd0);
    check_regs("reset");

    // R5 clean traffic across a sequence wrap, R3
    for (int i = 0; i < 10; i++) good(2'(i % 3), 7'd0, 3'd0, 32'hA000 + i);
    // R6 nonzero status in read/write/mode
    good(2'd0, 7'h11, 3'd1, 32'hB0);
    good(2'd1, 7'h22, 3'd2, 32'hB1);
    good(2'd2, 7'h7F, 3'd3, 32'hB2);
    // R5 error-response kind with zero status forwards
    good(2'd3, 7'd0, 3'd4, 32'hB3);
    check_regs("clean");

    // R1 length errors
    send(2'd0, 4'd2, 4'd3, 1'b1, m_seq, 7'd0, 3'd0, 32'hC0);
    send(2'd0, 4'd0, 4'd0, 1'b1, m_seq, 7'd0, 3'd0, 32'hC1);
    send(2'd0, 4'd10, 4'd10, 1'b1, m_seq, 7'd0, 3'd0, 32'hC2);
    check_regs("R1");
    wr(2'd1, 16'h0001); m_irq[0] = 1'b0;
    // R2 CRC
    send(2'd1, 4'd9, 4'd9, 1'b0, m_seq, 7'd0, 3'd0, 32'hC3);
    check_regs("R2");
    // R3 wrong sequence, then expected one still accepted
    send(2'd1, 4'd4, 4'd4, 1'b1, m_seq + 3'd1, 7'd0, 3'd0, 32'hC4);
    good(2'd1, 7'd0, 3'd0, 32'hC5);
    check_regs("R3");
    // R10 partial clear
    wr(2'd1, 16'h0004); m_irq[2] = 1'b0;
    check_regs("R10 partial");
    wr(2'd1, 16'h0007); m_irq = '0;
    check_regs("R10 full");

    // R7/R8 divert and pop order
    good(2'd3, 7'h05, 3'd6, 32'hD0);
    good(2'd0, 7'h00, 3'd0, 32'hD1);
    good(2'd3, 7'h41, 3'd2, 32'hD2);
    check_regs("R7");
    pop();
    check_regs("R8 pop1");
    pop();
    check_regs("R8 pop2");

    // R9 overflow
    for (int i = 0; i < 9; i++) good(2'd3, 7'(i + 1), 3'(i), 32'hE0 + i);
    check_regs("R9 full");
    wr(2'd0, 16'h8000); m_ovf = 1'b0;
    check_regs("R9 clear");
    for (int i = 0; i < 8; i++) begin pop(); check_regs("R8 drain"); end

    // R4 saturation
    for (int i = 0; i < 260; i++) send(2'd0, 4'd1, 4'd1, 1'b0, m_seq, 7'd0, 3'd0, 32'hF);
    check_regs("R4 sat");

    repeat (3) @(negedge clk);
    chk("R5 all forwards seen", 35'(sb.size()), 35'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule